// File: doc/BRIEF.md
# Programmable Power-of-Two Delay Divider

This block measures the delay of a one-shot timer by counting enabled clocks in a 24-stage binary chain. A four-bit select picks the stage whose carry ends the delay, so the delay is always a power-of-two number of enabled clocks. A synchronous clear restarts the measurement and is raised both on the first trigger and on each retrigger. When the selected stage carries out, the block raises a terminal-count pulse for exactly one cycle. At the same edge all stages return to zero, and they stay idle until the next clear.

The top select bit chooses between two layouts. In chained layout the 24 stages form one counter. In split layout the chain is cut into three 8-stage sections, and all three advance on every enabled clock. The split layout exists for test: 255 enabled clocks drive every stage to one. Switching back to the longest chained ratio then lets one more clock prove the full rollover. That check takes 256 clocks instead of about 16.7 million.

Top module: `prog_delay_divider`

## Requirements
- R1: While `rst_n` is low, `stage_q` is zero and `tc_pulse` is low. After reset the block is idle: `stage_q` holds at zero even with `cnt_en` high, until `sync_clr` has been seen.
- R2: With `sync_clr` high at a clock edge, `stage_q` becomes zero at that edge and the block becomes armed. The clear overrides counting and overrides a terminal count in the same cycle.
- R3: Chained layout, selected by `sel[3]`=1, with k=`sel[2:0]`: the divide ratio is 2^(3k+3), which gives 8, 64, 512 and so on up to 2^24 for k=7. While armed, `stage_q` equals the number of enabled clocks since the clear. The terminal count fires on the enabled clock numbered with the ratio.
- R4: Split layout, selected by `sel[3]`=0, with k=`sel[2:0]`: the ratio is 2^(k+1), from 2 up to 256. Each of the three 8-bit sections (`stage_q[7:0]`, `[15:8]`, `[23:16]`) holds the count of enabled clocks modulo 256.
- R5: In split layout with `sel`=4'b0111, 255 enabled clocks after a clear make `stage_q` equal to 24'hFFFFFF, with no terminal count.
- R6: From `stage_q`=24'hFFFFFF with `sel`=4'b1111, one enabled clock returns every stage to zero and raises `tc_pulse`.
- R7: `tc_pulse` is high for exactly one cycle, and it is high in the same cycle that `stage_q` reads zero after the final edge.
- R8: After a terminal count, `stage_q` stays at zero and no further pulse occurs, whatever `cnt_en` does, until the next `sync_clr`.
- R9: While armed, a clock with `cnt_en` low leaves `stage_q` unchanged, so the terminal count arrives only after the full number of enabled clocks.
- R10: Driving `rst_n` low clears `stage_q` and `tc_pulse` at once, without waiting for a clock edge. Reset takes priority over `sync_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear; arms a new delay (trigger/retrigger) |
| cnt_en | input | 1 | Clock enable for the stages |
| sel | input | 4 | Bit 3 picks chained (1) or split (0) layout; bits 2:0 pick the ratio |
| stage_q | output | 24 | Present value of all stages |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |

## Verification
The hardest state to reach from the ports is the full 2^24 rollover, because counting up to it takes more clocks than the run allows. The stimulus reaches it the way the block intends. It selects split layout with the 256 ratio and applies 255 enabled clocks. It then checks that every stage reads one, flips `sel` to the longest chained ratio, and applies one more clock. Separately, every split code and the five shortest chained codes are swept to terminal count, and the number of clocks measured is compared with the ratio computed from the select value.

// File: rtl/pdd_pkg.sv
// Shared definitions for the programmable delay divider.
// Assumes the chain length is a whole number of equal sections.
package pdd_pkg;

    typedef enum logic { LAYOUT_SPLIT = 1'b0, LAYOUT_CHAIN = 1'b1 } layout_e;

    // Exponent of the divide ratio for a layout and a low select code.
    // Chained layout advances by one section count per code step; split
    // layout advances by one stage per step. Result is clamped to [1, limit].
    function automatic int ratio_exponent(layout_e layout, int code, int nsect, int limit);
        int e;
        e = (layout == LAYOUT_CHAIN) ? (code + 1) * nsect : (code + 1);
        if (e > limit) e = limit;
        if (e < 1) e = 1;
        return e;
    endfunction

endpackage

// File: rtl/pdd_sel_decode.sv
// Select decoder: turns the select bus into a layout flag and a mask of the
// stages that must all be one before the next enabled clock ends the delay.
// Assumes SECT_W >= 2^(SEL_W-1) so every split code fits in one section.
module pdd_sel_decode
    import pdd_pkg::*;
#(
    parameter int STAGES = 24,
    parameter int SECT_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic [SEL_W-1:0]  sel,
    output logic              split,
    output logic [STAGES-1:0] tap_mask
);
    localparam int NSECT = STAGES / SECT_W;

    layout_e layout;
    int      exp_w;

    // Decode layout and exponent, then build a thermometer mask below it.
    always_comb begin
        layout = sel[SEL_W-1] ? LAYOUT_CHAIN : LAYOUT_SPLIT;
        split  = (layout == LAYOUT_SPLIT);
        exp_w  = ratio_exponent(layout, int'(sel[SEL_W-2:0]), NSECT,
                                split ? SECT_W : STAGES);
        for (int i = 0; i < STAGES; i++) begin
            tap_mask[i] = (i < exp_w);
        end
    end

endmodule

// File: rtl/pdd_section.sv
// One section of the stage chain: a binary counter that clears
// synchronously and advances when its increment input is high.
// Assumes the clear has priority over the increment.
module pdd_section #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         full
);
    // Section register: asynchronous reset, then clear, then advance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (inc) q <= q + 1'b1;
    end

    // All stages of this section are one: the carry condition for the next section.
    assign full = &q;

endmodule

// File: rtl/prog_delay_divider.sv
// Programmable power-of-two delay divider with a split test layout.
// Counts enabled clocks after a synchronous clear. It pulses terminal count
// when the selected stage carries out, then clears and idles until the next
// clear. Assumes STAGES is a multiple of SECT_W.
module prog_delay_divider
    import pdd_pkg::*;
#(
    parameter int STAGES = 24,
    parameter int SECT_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              cnt_en,
    input  logic [SEL_W-1:0]  sel,
    output logic [STAGES-1:0] stage_q,
    output logic              tc_pulse
);
    localparam int NSECT = STAGES / SECT_W;

    logic              split;
    logic [STAGES-1:0] tap_mask;
    logic              idle_q;
    logic              step;
    logic              tc_hit;
    logic [NSECT-1:0]  chain;
    logic [NSECT-1:0]  sect_full;

    pdd_sel_decode #(.STAGES(STAGES), .SECT_W(SECT_W), .SEL_W(SEL_W)) u_dec (
        .sel      (sel),
        .split    (split),
        .tap_mask (tap_mask)
    );

    // An advance happens only when armed, enabled, and not being cleared.
    assign step   = cnt_en & ~idle_q & ~sync_clr;
    // The delay ends when every masked stage is one and one more step arrives.
    assign tc_hit = step & (&(stage_q | ~tap_mask));
    assign chain[0] = step;

    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        logic inc_s;
        // Split layout advances every section; chained layout ripples the carry.
        assign inc_s = split ? step : chain[s];
        pdd_section #(.W(SECT_W)) u_sect (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (sync_clr | tc_hit),
            .inc   (inc_s),
            .q     (stage_q[s*SECT_W +: SECT_W]),
            .full  (sect_full[s])
        );
        if (s < NSECT - 1) begin : g_carry
            assign chain[s+1] = chain[s] & sect_full[s];
        end
    end

    // Armed/idle state: idle after reset and after a terminal count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        idle_q <= 1'b1;
        else if (sync_clr) idle_q <= 1'b0;
        else if (tc_hit)   idle_q <= 1'b1;
    end

    // Terminal-count pulse register: high for the one cycle after the final edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tc_pulse <= 1'b0;
        else        tc_pulse <= tc_hit;
    end

endmodule

// File: rtl/pdd_checker.sv
// Property checker for prog_delay_divider, attached with bind.
// Observes ports plus the armed/idle state that separates the control logic.
module pdd_checker #(
    parameter int STAGES = 24,
    parameter int SECT_W = 8,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_clr,
    input logic              cnt_en,
    input logic [SEL_W-1:0]  sel,
    input logic [STAGES-1:0] stage_q,
    input logic              tc_pulse,
    input logic              idle_q
);
    localparam int NSECT = STAGES / SECT_W;

    // R10: while reset is low, everything is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R10: assert (stage_q == '0 && !tc_pulse)
                else $error("reset did not clear stages");
        end
    end

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (stage_q == '0 && !tc_pulse && !idle_q));

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);

    assert_pulse_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> (stage_q == '0));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q && !sync_clr) |=> (stage_q == '0 && !tc_pulse));

    assert_enable_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !sync_clr) |=> ($stable(stage_q) && !tc_pulse));

    assert_chain_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_q && cnt_en && !sync_clr && sel[SEL_W-1])
        |=> ((stage_q == $past(stage_q) + 1'b1) || (stage_q == '0 && tc_pulse)));

    for (genvar s = 0; s < NSECT; s++) begin : g_chk
        assert_split_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!idle_q && cnt_en && !sync_clr && !sel[SEL_W-1])
            |=> ((stage_q[s*SECT_W +: SECT_W] == SECT_W'($past(stage_q[s*SECT_W +: SECT_W]) + 1'b1))
                 || (stage_q == '0 && tc_pulse)));
    end

endmodule

bind prog_delay_divider pdd_checker #(.STAGES(STAGES), .SECT_W(SECT_W), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_clr (sync_clr),
    .cnt_en   (cnt_en),
    .sel      (sel),
    .stage_q  (stage_q),
    .tc_pulse (tc_pulse),
    .idle_q   (idle_q)
);

// File: tb/prog_delay_divider_test.sv
// Self-checking bench: sweeps split and short chained codes to terminal count,
// runs the split-preset rollover check, enable gating and asynchronous reset.
module prog_delay_divider_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_clr = 1'b0;
    logic        cnt_en = 1'b0;
    logic [3:0]  sel = 4'b0000;
    logic [23:0] stage_q;
    logic        tc_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    prog_delay_divider uut (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .cnt_en(cnt_en),
        .sel(sel), .stage_q(stage_q), .tc_pulse(tc_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Advance one clock and settle away from the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Clear, then count enabled clocks until the pulse; return the count.
    task automatic run_to_tc(input logic [3:0] s, input int limit, output int n);
        sel = s; sync_clr = 1'b1; cnt_en = 1'b1;
        tick();
        sync_clr = 1'b0;
        n = 0;
        while (n < limit) begin
            tick();
            n++;
            if (tc_pulse) break;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int ratio;
        logic [23:0] held;

        // R1: reset state and idle after release.
        #3;
        chk(stage_q == 24'h0 && !tc_pulse, "R1", "reset outputs", stage_q, 0);
        tick(); tick();
        rst_n = 1'b1; cnt_en = 1'b1; sel = 4'b1000;
        for (int i = 0; i < 4; i++) tick();
        chk(stage_q == 24'h0 && !tc_pulse, "R1", "idle before clear", stage_q, 0);

        // R4: sweep every split code to terminal count.
        for (int k = 0; k < 8; k++) begin
            ratio = 1 << (k + 1);
            run_to_tc({1'b0, 3'(k)}, ratio + 4, n);
            chk(n == ratio, "R4", $sformatf("split k=%0d clocks", k), n, ratio);
            chk(stage_q == 24'h0, "R7", "zero at pulse", stage_q, 0);
            tick();
            chk(!tc_pulse, "R7", "pulse one cycle", tc_pulse, 0);
            tick(); tick();
            chk(stage_q == 24'h0 && !tc_pulse, "R8", "hold after tc", stage_q, 0);
        end

        // R3: sweep the five shortest chained codes.
        for (int k = 0; k < 5; k++) begin
            ratio = 1 << (3 * (k + 1));
            run_to_tc({1'b1, 3'(k)}, ratio + 4, n);
            chk(n == ratio, "R3", $sformatf("chain k=%0d clocks", k), n, ratio);
            chk(stage_q == 24'h0, "R7", "chain zero at pulse", stage_q, 0);
        end

        // R3: intermediate chained value equals the clock count.
        sel = 4'b1111; sync_clr = 1'b1; tick(); sync_clr = 1'b0;
        for (int i = 0; i < 300; i++) tick();
        chk(stage_q == 24'd300, "R3", "chain value after 300", stage_q, 300);

        // R2: clear in the middle of a count, with enable high.
        sync_clr = 1'b1; tick();
        chk(stage_q == 24'h0 && !tc_pulse, "R2", "clear mid-count", stage_q, 0);
        sync_clr = 1'b0;

        // R4: split value shows the same count in every section.
        sel = 4'b0111; sync_clr = 1'b1; tick(); sync_clr = 1'b0;
        for (int i = 0; i < 37; i++) tick();
        chk(stage_q == 24'h252525, "R4", "split sections equal", stage_q, 24'h252525);

        // R5 and R6: split preset then full rollover.
        sync_clr = 1'b1; tick(); sync_clr = 1'b0;
        n = 0;
        for (int i = 0; i < 255; i++) begin
            tick();
            if (tc_pulse) n++;
        end
        chk(stage_q == 24'hFFFFFF && n == 0, "R5", "all stages one", stage_q, 24'hFFFFFF);
        sel = 4'b1111;
        tick();
        chk(stage_q == 24'h0 && tc_pulse, "R6", "rollover to zero with pulse",
            {tc_pulse, stage_q}, 25'h1000000);
        tick();
        chk(!tc_pulse && stage_q == 24'h0, "R7", "rollover pulse one cycle", tc_pulse, 0);

        // R9: gated enable doubles the clock count; held value on idle clocks.
        sel = 4'b0010; sync_clr = 1'b1; tick(); sync_clr = 1'b0;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            cnt_en = (i % 2 == 0);
            held = stage_q;
            tick();
            n++;
            if (!cnt_en)
                chk(stage_q == held, "R9", "frozen when disabled", stage_q, held);
            if (tc_pulse) break;
        end
        chk(n == 15, "R9", "gated clocks to tc", n, 15);
        cnt_en = 1'b1;

        // R10: asynchronous reset mid-count, over a clear.
        sel = 4'b1111; sync_clr = 1'b1; tick(); sync_clr = 1'b0;
        for (int i = 0; i < 20; i++) tick();
        #2;
        rst_n = 1'b0; sync_clr = 1'b1;
        #1;
        chk(stage_q == 24'h0 && !tc_pulse, "R10", "async clear", stage_q, 0);
        tick();
        sync_clr = 1'b0;
        tick();
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        chk(stage_q == 24'h0, "R10", "idle after reset release", stage_q, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule